// File: doc/BRIEF.md
# Framed serial sample output port

This block takes one complex sample (an I word and a Q word) per output frame and shifts it out, MSB first, on a small group of serial data lines. A frame strobe marks where each word begins. The frame length is the decimation interval, counted in processing clocks. Each serial bit is held for a programmable number of processing clocks. The strobe width, and how many clocks the strobe leads the MSB, are both programmable, so the receiving logic can be given extra set-up time.

There are two lane layouts. In the two-line layout, I goes on line 0 and Q on line 1. In the four-line layout, each word is split into an upper half and a lower half, and each half goes on its own line.

The configuration inputs are taken only at frame boundaries. A setting whose serial word does not fit in the frame raises an error flag, and the port stays silent while that setting is active. One sample can wait while a word is being shifted out; any further samples in that window are dropped and counted.

Top module: `frame_serial_out`

## Requirements
- R1: Each serial bit is held for exactly cfg_div+1 processing clocks (cfg_div=0 gives one clock per bit). Bits leave MSB first.
- R2: Frames are cfg_decim clocks long. When a sample is ready for every frame, the strobe rises exactly once per frame, cfg_decim clocks after the previous rise.
- R3: The strobe stays high for exactly cfg_strb_w processing clocks from its rising edge, then goes low for the rest of the frame.
- R4: The MSB is first driven cfg_adv clocks after the strobe rises. With cfg_adv=0 this is the same clock as the rise. Before the MSB, the data lines are 0.
- R5: With cfg_four=0 (two-line layout), line 0 carries the low cfg_width bits of I and line 1 carries the low cfg_width bits of Q. Lines 2 and 3 stay 0.
- R6: With cfg_four=1 (four-line layout), h=cfg_width/2. Line 0 carries I bits [cfg_width-1:h], line 1 carries I bits [h-1:0], line 2 carries Q bits [cfg_width-1:h] and line 3 carries Q bits [h-1:0]. Each line carries h bits.
- R7: After the LSB, the data lines hold 0 until the next MSB. In a frame with no sample waiting, the strobe stays low and all lines are 0.
- R8: Let n be the bits per line (cfg_width for cfg_four=0, cfg_width/2 for cfg_four=1). A setting is legal when all of the following hold:
  - 1 <= cfg_width <= 24;
  - cfg_width is even when cfg_four=1;
  - 1 <= cfg_strb_w < cfg_decim;
  - cfg_adv + n*(cfg_div+1) <= cfg_decim.
  While an illegal setting is active, cfg_err is 1, the strobe and data lines stay 0, and incoming samples are ignored (not sent and not counted). cfg_err returns to 0 once a legal setting is taken at a frame boundary.
- R9: A sample that arrives while no other sample is waiting is held and sent in the next frame. Each sample that arrives while one is already waiting is dropped and increments drop_count by 1.
- R10: The configuration inputs take effect only at a frame boundary. Changing them in the middle of a frame leaves the word being sent, and the length of that frame, unchanged.
- R11: While reset is held and just after it, ser_data, frame_strb, cfg_err and drop_count are all 0, provided the configuration inputs are legal at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_four | input | 1 | Lane layout: 0 = two lines, 1 = four lines |
| cfg_width | input | 5 | Word width in bits |
| cfg_div | input | 4 | Bit-clock divider; a bit lasts cfg_div+1 clocks |
| cfg_decim | input | 12 | Frame length in processing clocks |
| cfg_strb_w | input | 4 | Strobe width in processing clocks |
| cfg_adv | input | 4 | Clocks by which the strobe leads the MSB |
| smp_valid | input | 1 | One-clock pulse: new sample on smp_i and smp_q |
| smp_i | input | 24 | I word, right-aligned |
| smp_q | input | 24 | Q word, right-aligned |
| ser_data | output | 4 | Serial data lines |
| frame_strb | output | 1 | Frame strobe |
| cfg_err | output | 1 | The active setting does not fit the frame |
| drop_count | output | 8 | Count of dropped samples, wrapping |

## Verification
Random legal settings are run with random I and Q words in both lane layouts. These runs tell a wrong lane mapping or bit order apart from a wrong bit period or strobe lead.

Directed cases cover the following:
- a setting that fills the frame exactly, and the same setting with one clock more of strobe lead, which must raise the error flag;
- a word width that is too wide at the divided rate (error), followed by recovery;
- three samples in one frame, which exposes faults in holding and dropping;
- a configuration change part-way through a word, which shows whether settings leak into the word already being sent.

// File: rtl/frame_serial_pkg.sv
package frame_serial_pkg;

  typedef enum logic {
    LAYOUT_TWO  = 1'b0,
    LAYOUT_FOUR = 1'b1
  } layout_e;

  // Legality of a frame setting: the serial word plus the strobe lead must fit in the frame.
  function automatic logic cfg_fits(input int w, input int maxw, input logic four,
                                    input int div, input int adv, input int sw,
                                    input int decim);
    int nb;
    if (w < 1 || w > maxw) return 1'b0;
    if (four && (w % 2 != 0)) return 1'b0;
    if (sw < 1 || sw >= decim) return 1'b0;
    nb = four ? (w / 2) : w;
    return (adv + nb * (div + 1)) <= decim;
  endfunction

endpackage

// File: rtl/fso_frame_timer.sv
module fso_frame_timer #(
  parameter int MAX_W = 24,
  parameter int WID_W = 5,
  parameter int DIV_W = 4,
  parameter int DCM_W = 12,
  parameter int SW_W  = 4,
  parameter int ADV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_four,
  input  logic [WID_W-1:0] cfg_width,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [DCM_W-1:0] cfg_decim,
  input  logic [SW_W-1:0]  cfg_strb_w,
  input  logic [ADV_W-1:0] cfg_adv,
  output logic [DCM_W-1:0] fc,
  output logic             bnd,
  output logic             nxt_legal,
  output logic             a_four,
  output logic [WID_W-1:0] a_width,
  output logic [DIV_W-1:0] a_div,
  output logic [SW_W-1:0]  a_sw,
  output logic [ADV_W-1:0] a_adv,
  output logic             a_err
);
  import frame_serial_pkg::*;

  logic [DCM_W-1:0] a_decim;
  logic [DCM_W:0]   fc_inc;

  assign fc_inc    = {1'b0, fc} + 1'b1;
  assign bnd       = fc_inc >= {1'b0, a_decim};
  assign nxt_legal = cfg_fits(int'(cfg_width), MAX_W, cfg_four, int'(cfg_div),
                              int'(cfg_adv), int'(cfg_strb_w), int'(cfg_decim));

  // Settings are captured at reset and at each frame boundary only.
  always_ff @(posedge clk) begin
    if (rst || bnd) begin
      fc      <= '0;
      a_four  <= cfg_four;
      a_width <= cfg_width;
      a_div   <= cfg_div;
      a_decim <= cfg_decim;
      a_sw    <= cfg_strb_w;
      a_adv   <= cfg_adv;
      a_err   <= !nxt_legal;
    end else begin
      fc <= fc + 1'b1;
    end
  end

  // R2
  fc_range_chk: assert property (@(posedge clk) disable iff (rst)
    !a_err |-> (fc < a_decim));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bnd) && !$past(rst)) |-> ($stable(a_width) && $stable(a_decim) && $stable(a_div)));

endmodule

// File: rtl/fso_sample_hold.sv
module fso_sample_hold #(
  parameter int MAX_W  = 24,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [MAX_W-1:0]  smp_i,
  input  logic [MAX_W-1:0]  smp_q,
  input  logic              block,
  input  logic              bnd,
  output logic              pend_v,
  output logic [MAX_W-1:0]  pend_i,
  output logic [MAX_W-1:0]  pend_q,
  output logic [DROP_W-1:0] drop_count
);
  logic accept;

  assign accept = smp_valid && !block;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_i     <= '0;
      pend_q     <= '0;
      drop_count <= '0;
    end else if (bnd) begin
      // The waiting sample moves to the lanes; the slot frees in the same clock.
      pend_v <= accept;
      if (accept) begin
        pend_i <= smp_i;
        pend_q <= smp_q;
      end
    end else if (accept) begin
      if (pend_v) begin
        drop_count <= drop_count + 1'b1;
      end else begin
        pend_v <= 1'b1;
        pend_i <= smp_i;
        pend_q <= smp_q;
      end
    end
  end

  // R9
  drop_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !bnd && pend_v) |=> (drop_count == $past(drop_count) + 1'b1));

  // R9
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(drop_count));

  // R8
  block_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (block && !bnd) |=> ($stable(pend_v) && $stable(drop_count)));

endmodule

// File: rtl/fso_bit_pacer.sv
module fso_bit_pacer #(
  parameter int WID_W = 5,
  parameter int DIV_W = 4,
  parameter int DCM_W = 12,
  parameter int ADV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bnd,
  input  logic             start,
  input  logic [DCM_W-1:0] fc,
  input  logic [ADV_W-1:0] adv,
  input  logic [DIV_W-1:0] div,
  input  logic [WID_W-1:0] nb,
  output logic             run,
  output logic             shift,
  output logic             frame_on
);
  logic             act;
  logic [DIV_W-1:0] dcnt;
  logic [WID_W-1:0] bcnt;

  assign run   = act && (fc >= DCM_W'(adv));
  assign shift = run && (dcnt == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      frame_on <= 1'b0;
      dcnt     <= '0;
      bcnt     <= '0;
    end else if (bnd) begin
      act      <= start;
      frame_on <= start;
      dcnt     <= '0;
      bcnt     <= '0;
    end else if (run) begin
      if (dcnt == div) begin
        dcnt <= '0;
        if (bcnt == nb - 1'b1) act <= 1'b0;
        else                   bcnt <= bcnt + 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  // R1
  bit_count_chk: assert property (@(posedge clk) disable iff (rst)
    act |-> (bcnt < nb));

  // R7
  act_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    act |-> frame_on);

endmodule

// File: rtl/fso_lane.sv
module fso_lane #(
  parameter int MAX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [MAX_W-1:0] word,
  output logic             msb
);
  logic [MAX_W-1:0] sh;

  assign msb = sh[MAX_W-1];

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= word;
    else if (shift) sh <= {sh[MAX_W-2:0], 1'b0};
  end

endmodule

// File: rtl/frame_serial_out.sv
module frame_serial_out #(
  parameter int MAX_W  = 24,
  parameter int DIV_W  = 4,
  parameter int DCM_W  = 12,
  parameter int SW_W   = 4,
  parameter int ADV_W  = 4,
  parameter int DROP_W = 8,
  localparam int WID_W = $clog2(MAX_W + 1),
  localparam int LANES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_four,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DCM_W-1:0]  cfg_decim,
  input  logic [SW_W-1:0]   cfg_strb_w,
  input  logic [ADV_W-1:0]  cfg_adv,
  input  logic              smp_valid,
  input  logic [MAX_W-1:0]  smp_i,
  input  logic [MAX_W-1:0]  smp_q,
  output logic [LANES-1:0]  ser_data,
  output logic              frame_strb,
  output logic              cfg_err,
  output logic [DROP_W-1:0] drop_count
);
  import frame_serial_pkg::*;

  logic [DCM_W-1:0] fc;
  logic             bnd, nxt_legal;
  logic             a_four, a_err;
  logic [WID_W-1:0] a_width, nb;
  logic [DIV_W-1:0] a_div;
  logic [SW_W-1:0]  a_sw;
  logic [ADV_W-1:0] a_adv;
  logic             pend_v;
  logic [MAX_W-1:0] pend_i, pend_q;
  logic             run, shift, frame_on;
  logic [LANES-1:0] lane_msb;
  logic [MAX_W-1:0] lw [LANES];
  logic [MAX_W-1:0] msk, mskh, iv, qv;
  int               fw, hw;

  fso_frame_timer #(.MAX_W(MAX_W), .WID_W(WID_W), .DIV_W(DIV_W), .DCM_W(DCM_W),
                    .SW_W(SW_W), .ADV_W(ADV_W)) u_timer (
    .clk(clk), .rst(rst), .cfg_four(cfg_four), .cfg_width(cfg_width),
    .cfg_div(cfg_div), .cfg_decim(cfg_decim), .cfg_strb_w(cfg_strb_w),
    .cfg_adv(cfg_adv), .fc(fc), .bnd(bnd), .nxt_legal(nxt_legal),
    .a_four(a_four), .a_width(a_width), .a_div(a_div), .a_sw(a_sw),
    .a_adv(a_adv), .a_err(a_err));

  fso_sample_hold #(.MAX_W(MAX_W), .DROP_W(DROP_W)) u_hold (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .block(a_err), .bnd(bnd), .pend_v(pend_v), .pend_i(pend_i), .pend_q(pend_q),
    .drop_count(drop_count));

  assign nb = (a_four == LAYOUT_FOUR) ? (a_width >> 1) : a_width;

  fso_bit_pacer #(.WID_W(WID_W), .DIV_W(DIV_W), .DCM_W(DCM_W), .ADV_W(ADV_W)) u_pacer (
    .clk(clk), .rst(rst), .bnd(bnd), .start(pend_v && nxt_legal), .fc(fc),
    .adv(a_adv), .div(a_div), .nb(nb), .run(run), .shift(shift),
    .frame_on(frame_on));

  // Lane words are formed from the waiting sample with the setting taken at the boundary.
  always_comb begin
    fw   = int'(cfg_width);
    hw   = fw / 2;
    msk  = ~({MAX_W{1'b1}} << cfg_width);
    mskh = ~({MAX_W{1'b1}} << (cfg_width >> 1));
    iv   = pend_i & msk;
    qv   = pend_q & msk;
    if (cfg_four == LAYOUT_FOUR) begin
      lw[0] = (iv >> hw) << (MAX_W - hw);
      lw[1] = (iv & mskh) << (MAX_W - hw);
      lw[2] = (qv >> hw) << (MAX_W - hw);
      lw[3] = (qv & mskh) << (MAX_W - hw);
    end else begin
      lw[0] = iv << (MAX_W - fw);
      lw[1] = qv << (MAX_W - fw);
      lw[2] = '0;
      lw[3] = '0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fso_lane #(.MAX_W(MAX_W)) u_lane (
      .clk(clk), .rst(rst), .load(bnd), .shift(shift), .word(lw[g]),
      .msb(lane_msb[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_data   <= '0;
      frame_strb <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      ser_data   <= run ? lane_msb : '0;
      frame_strb <= frame_on && (fc < DCM_W'(a_sw));
      cfg_err    <= a_err;
    end
  end

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!frame_strb && (ser_data == '0)));

  // R7
  no_word_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_on) |-> (!frame_strb && (ser_data == '0)));

endmodule

// File: tb/frame_serial_out_test.sv
`timescale 1ns/1ps
module frame_serial_out_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_four;
  logic [4:0]  cfg_width;
  logic [3:0]  cfg_div;
  logic [11:0] cfg_decim;
  logic [3:0]  cfg_strb_w;
  logic [3:0]  cfg_adv;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_i = '0, smp_q = '0;
  logic [3:0]  ser_data;
  logic        frame_strb, cfg_err;
  logic [7:0]  drop_count;

  int n_tests = 0, n_fail = 0;
  int c_four, c_w, c_div, c_dec, c_sw, c_adv;
  int x_four, x_w, x_div, x_dec, x_sw, x_adv;
  int exp_drop = 0;

  always #10 clk = ~clk;

  frame_serial_out uut (
    .clk(clk), .rst(rst), .cfg_four(cfg_four), .cfg_width(cfg_width),
    .cfg_div(cfg_div), .cfg_decim(cfg_decim), .cfg_strb_w(cfg_strb_w),
    .cfg_adv(cfg_adv), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .ser_data(ser_data), .frame_strb(frame_strb), .cfg_err(cfg_err),
    .drop_count(drop_count));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int four, w, dv, dec, sw, ad);
    cfg_four = four[0]; cfg_width = 5'(w); cfg_div = 4'(dv);
    cfg_decim = 12'(dec); cfg_strb_w = 4'(sw); cfg_adv = 4'(ad);
    c_four = four; c_w = w; c_div = dv; c_dec = dec; c_sw = sw; c_adv = ad;
  endtask

  function automatic bit exp_bit(input int four, w, input logic [23:0] i, q,
                                 input int lane, k);
    int h;
    h = w / 2;
    if (four == 0) begin
      if (lane == 0) return i[w-1-k];
      if (lane == 1) return q[w-1-k];
      return 1'b0;
    end
    case (lane)
      0: return i[w-1-k];
      1: return i[h-1-k];
      2: return q[w-1-k];
      default: return q[h-1-k];
    endcase
  endfunction

  // Checks the whole window with strobe and data low.
  task automatic idle(input int n, input string req);
    int bad = 0;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (frame_strb !== 1'b0 || ser_data !== 4'd0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic send1(input logic [23:0] i, q);
    @(negedge clk);
    smp_valid = 1'b1; smp_i = i; smp_q = q;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_rise(input int lim);
    int t = 0;
    while (frame_strb !== 1'b1 && t < lim) begin
      @(negedge clk);
      t++;
    end
    check(frame_strb === 1'b1, "R2 strobe after sample", t, lim);
  endtask

  // Entered at the clock the strobe has risen (t=0); leaves at t=D.
  task automatic capture(input logic [23:0] ei, eq, input int nfeed,
                         input logic [23:0] ni, nq, input bit chg);
    int d, dv, ad, sw, w, f, nb, es, em, eb, ez, k;
    bit e;
    d = c_dec; dv = c_div; ad = c_adv; sw = c_sw; w = c_w; f = c_four;
    nb = f ? w / 2 : w;
    es = 0; em = 0; eb = 0; ez = 0;
    for (int t = 0; t < d; t++) begin
      if (t > 0) @(negedge clk);
      if (frame_strb !== (t < sw)) es++;
      for (int l = 0; l < 4; l++) begin
        if (t >= ad && (t - ad) < nb * (dv + 1)) begin
          k = (t - ad) / (dv + 1);
          e = (l < (f ? 4 : 2)) ? exp_bit(f, w, ei, eq, l, k) : 1'b0;
          if (ser_data[l] !== e) begin
            if (k == 0) em++; else eb++;
          end
        end else if (ser_data[l] !== 1'b0) begin
          if (t < ad) em++; else ez++;
        end
      end
      if (nfeed > 0 && t == 2) begin
        smp_valid = 1'b1; smp_i = ni; smp_q = nq;
      end
      if (nfeed > 1 && t == 3) smp_i = ni ^ 24'h5A5A5A;
      if (nfeed > 2 && t == 4) smp_i = ni ^ 24'hA5A5A5;
      if (nfeed > 0 && t == 2 + nfeed) smp_valid = 1'b0;
      if (chg && t == 3) set_cfg(x_four, x_w, x_div, x_dec, x_sw, x_adv);
    end
    if (nfeed > 0 && 2 + nfeed >= d) smp_valid = 1'b0;
    @(negedge clk);
    check(frame_strb === (nfeed > 0), "R2 strobe period", int'(frame_strb), int'(nfeed > 0));
    check(es == 0, "R3 strobe width", es, 0);
    check(em == 0, "R4 MSB position after strobe", em, 0);
    check(eb == 0, f ? "R6 four-line bits (R1 period)" : "R5 two-line bits (R1 period)", eb, 0);
    check(ez == 0, "R7 zero after LSB", ez, 0);
    if (nfeed > 1) exp_drop += nfeed - 1;
    check(drop_count == 8'(exp_drop), "R9 drop count", int'(drop_count), exp_drop);
  endtask

  // Sends nw words back to back; drop_at feeds three samples, chg_at switches to x_* mid-word.
  task automatic run_seq(input int nw, input int drop_at, input int chg_at);
    logic [23:0] si, sq, ni, nq;
    si = 24'($urandom); sq = 24'($urandom);
    send1(si, sq);
    wait_rise(2 * c_dec + 4);
    for (int n = 0; n < nw; n++) begin
      ni = 24'($urandom); nq = 24'($urandom);
      capture(si, sq, (n + 1 < nw) ? ((n == drop_at) ? 3 : 1) : 0, ni, nq, n == chg_at);
      si = ni; sq = nq;
    end
  endtask

  task automatic new_cfg(input int four, w, dv, dec, sw, ad, input bit err);
    int old = c_dec;
    set_cfg(four, w, dv, dec, sw, ad);
    idle(old + dec + 6, "R7 idle without sample");
    check(cfg_err === err, "R8 error flag", int'(cfg_err), int'(err));
  endtask

  initial begin
    int nb, dec, four, w;
    void'($urandom(32'd2024));
    set_cfg(0, 16, 0, 32, 1, 0);
    repeat (3) @(negedge clk);
    check(ser_data === 4'd0 && frame_strb === 1'b0, "R11 outputs in reset", int'(ser_data), 0);
    rst = 1'b0;
    @(negedge clk);
    check(ser_data === 4'd0 && frame_strb === 1'b0 && cfg_err === 1'b0,
          "R11 outputs after reset", int'({cfg_err, frame_strb, ser_data}), 0);
    check(drop_count === 8'd0, "R11 drop count after reset", int'(drop_count), 0);
    run_seq(3, -1, -1);

    // Exact fit, then one clock more of lead.
    new_cfg(0, 16, 1, 32, 1, 0, 1'b0);
    run_seq(3, -1, -1);
    new_cfg(0, 16, 1, 32, 1, 1, 1'b1);

    // Too wide at the divided rate: error, samples ignored.
    new_cfg(0, 18, 1, 32, 1, 0, 1'b1);
    send1(24'h123456, 24'h654321);
    send1(24'h0F0F0F, 24'hF0F0F0);
    idle(96, "R8 silent while in error");
    check(drop_count == 8'(exp_drop), "R8 samples ignored in error", int'(drop_count), exp_drop);
    new_cfg(0, 18, 0, 32, 2, 3, 1'b0);
    run_seq(3, -1, -1);

    // Four-line layout with lead, and a drop burst.
    new_cfg(1, 18, 0, 16, 2, 3, 1'b0);
    run_seq(4, 1, -1);

    // Mid-word change of settings.
    new_cfg(1, 12, 2, 24, 3, 1, 1'b0);
    x_four = 0; x_w = 10; x_div = 1; x_dec = 30; x_sw = 1; x_adv = 2;
    run_seq(3, -1, 0);
    check(c_w == 10, "R10 new setting used next frame", c_w, 10);

    for (int r = 0; r < 6; r++) begin
      four = $urandom % 2;
      w = four ? 2 * (1 + $urandom % 12) : 1 + $urandom % 24;
      nb = four ? w / 2 : w;
      dv = $urandom % 4;
      ad = $urandom % 4;
      dec = ad + nb * (dv + 1) + $urandom % 6;
      if (dec < 8) dec = 8;
      new_cfg(four, w, dv, dec, 1 + $urandom % 4, ad, 1'b0);
      run_seq(4, (r == 2) ? 2 : -1, -1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int dv, ad;

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule